// File: doc/BRIEF.md
# DAC Bring-up Sequencer with Lock Retries

This block takes a high-speed DAC from reset to a locked, running state through its configuration register port. After a start pulse it issues a fixed series of register writes, inserts long timed waits measured in data-clock cycles, and reads back lock-status registers. Each readback is compared against a value that depends on whether the converter is the sync master or a sync slave. A failed comparison sends the sequence back to the first write of the loop that produced it. When a phase fails too often, the sequence stops and returns a failure code.

Register traffic leaves the block as single transactions on a request/acknowledge port. A separate serial master turns them into wire-level frames and returns read data together with the acknowledge. The host sees `busy` while the sequence runs. When it ends, `done` rises and `err` gives the outcome. Both stay in place until the next start.

Top module: `dac_bringup_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, `busy`, `done`, `err` and `req` are all 0.
- R2: A run opens with writes in this order: 0x00←0x00, 0x00←0x20, 0x00←0x00, 0x22←0x0F, 0x23←0x0F, 0x24←0x30, 0x25←0x80, 0x27←0x46, 0x28←0x6C.
- R3: The delay-loop loop writes 0x29←0xCB, 0x26←0x02 and 0x26←0x03, waits, and then reads 0x2A, which must equal 0x01. On a mismatch the run resumes at the 0x29 write.
- R4: The sync loop writes 0x15←0x42, 0x10←0x00, and then 0x10←0x70 (master) or 0x10←0x50 (slave). It waits and reads 0x21, which must be 0x90 (master) or 0x00 (slave). It then reads 0x0D, whose bits [5:4] must be 2'b10; its other bits are ignored. Either mismatch resumes the run at the 0x15 write.
- R5: The receiver loop writes 0x13←0x72, then 0x10←0x70/0x50, then 0x10←0x73/0x53 (master/slave). It waits and reads 0x21, which must be 0x99 (master) or 0x09 (slave). On a mismatch the run resumes at the 0x13 write.
- R6: Every lock readback that follows a wait raises `req` exactly N+2 cycles after the clock edge that accepted the acknowledge of the preceding write. N is `DL_WAIT` for 0x2A and `SYNC_WAIT` for the sync read of 0x21. For the receiver read of 0x21, N is `RX_WAIT_SYNC` when sync is enabled and `RX_WAIT_NOSYNC` when it is not.
- R7: When a phase records its third mismatch (`MAX_TRIES`), the run stops at once and issues no further transactions. It then holds `done`=1, `busy`=0 and `err` = 1 (delay loop), 2 (sync) or 3 (receiver).
- R8: The attempt count is cleared when a phase passes. Mismatches in one phase never count against a later phase.
- R9: When sync is disabled at start, the whole sync loop (writes, wait and both reads) is skipped.
- R10: A run in which every phase passes ends with the writes 0x06←0x00, 0x07←0x02 and 0x08←0x00. It then holds `done`=1, `err`=0 and `busy`=0.
- R11: `master_sel` and `sync_en` are captured only by a start pulse accepted while idle. A start pulse while `busy` is high is ignored, and input changes during a run have no effect on it.
- R12: At most one transaction is outstanding. `req` stays high with `addr`, `wdata` and `rd_nwr` unchanged until the cycle in which `ack` is sampled, and drops on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data-domain clock; all waits count its cycles |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches a run when idle |
| master_sel | input | 1 | 1 = sync master, 0 = sync slave; sampled at start |
| sync_en | input | 1 | 1 = run the sync loop and use the long receiver wait; sampled at start |
| req | output | 1 | Transaction request, held until acknowledged |
| rd_nwr | output | 1 | 1 = read, 0 = write |
| addr | output | 8 | Register address of the transaction |
| wdata | output | 8 | Write data (0 on reads) |
| ack | input | 1 | One-cycle completion strobe from the serial master |
| rdata | input | 8 | Read data, valid in the cycle `ack` is high |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has ended; held until the next start |
| err | output | 2 | 0 ok, 1 delay-loop lock, 2 sync lock, 3 receiver lock |

## Verification
The bench builds the block with waits of 40, 50, 90 and 30 cycles in place of 160,000, 160,000, 555,000 and 135,000. This keeps every retry path and exhaustion path within a few hundred cycles while leaving `WAIT_W` at 20 bits and `MAX_TRIES` at 3. With these short waits the bench can check each wait gap to the exact cycle. It can also run dozens of full sequences, mixing master and slave, sync on and off, and zero to three forced mismatches for each readback.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  localparam int STEP_W = 5;

  typedef enum logic [1:0] {OP_WR, OP_RD, OP_WAIT, OP_END} op_e;
  typedef enum logic [1:0] {TW_LOOP, TW_SYNC, TW_RX} tsel_e;

  localparam logic [1:0] FAIL_NONE = 2'd0;
  localparam logic [1:0] FAIL_LOOP = 2'd1;
  localparam logic [1:0] FAIL_SYNC = 2'd2;
  localparam logic [1:0] FAIL_RX   = 2'd3;

  // One entry of the bring-up program. For reads, data is the expected value.
  typedef struct packed {
    op_e               op;
    logic [7:0]        addr;
    logic [7:0]        data;
    logic [7:0]        mask;
    logic [1:0]        code;
    logic              phase_end;
    logic              sync_only;
    logic [STEP_W-1:0] back;
    tsel_e             tsel;
  } step_t;

endpackage

// File: rtl/dbs_step_rom.sv
module dbs_step_rom
  import dbs_pkg::*;
(
  input  logic [STEP_W-1:0] idx,
  input  logic              master,
  output step_t             ent
);

  localparam logic [STEP_W-1:0] BACK_LOOP = STEP_W'(9);
  localparam logic [STEP_W-1:0] BACK_SYNC = STEP_W'(14);
  localparam logic [STEP_W-1:0] BACK_RX   = STEP_W'(20);

  logic [7:0] ctl_arm, ctl_go, sync_ok, rx_ok;

  always_comb begin
    ctl_arm = master ? 8'h70 : 8'h50;
    ctl_go  = master ? 8'h73 : 8'h53;
    sync_ok = master ? 8'h90 : 8'h00;
    rx_ok   = master ? 8'h99 : 8'h09;

    ent = '{op: OP_END, addr: 8'h00, data: 8'h00, mask: 8'hFF, code: FAIL_NONE,
            phase_end: 1'b0, sync_only: 1'b0, back: '0, tsel: TW_LOOP};
    case (idx)
      5'd0:  begin ent.op = OP_WR; ent.addr = 8'h00; ent.data = 8'h00; end
      5'd1:  begin ent.op = OP_WR; ent.addr = 8'h00; ent.data = 8'h20; end
      5'd2:  begin ent.op = OP_WR; ent.addr = 8'h00; ent.data = 8'h00; end
      5'd3:  begin ent.op = OP_WR; ent.addr = 8'h22; ent.data = 8'h0F; end
      5'd4:  begin ent.op = OP_WR; ent.addr = 8'h23; ent.data = 8'h0F; end
      5'd5:  begin ent.op = OP_WR; ent.addr = 8'h24; ent.data = 8'h30; end
      5'd6:  begin ent.op = OP_WR; ent.addr = 8'h25; ent.data = 8'h80; end
      5'd7:  begin ent.op = OP_WR; ent.addr = 8'h27; ent.data = 8'h46; end
      5'd8:  begin ent.op = OP_WR; ent.addr = 8'h28; ent.data = 8'h6C; end
      5'd9:  begin ent.op = OP_WR; ent.addr = 8'h29; ent.data = 8'hCB; end
      5'd10: begin ent.op = OP_WR; ent.addr = 8'h26; ent.data = 8'h02; end
      5'd11: begin ent.op = OP_WR; ent.addr = 8'h26; ent.data = 8'h03; end
      5'd12: begin ent.op = OP_WAIT; ent.tsel = TW_LOOP; end
      5'd13: begin
        ent.op = OP_RD; ent.addr = 8'h2A; ent.data = 8'h01;
        ent.code = FAIL_LOOP; ent.back = BACK_LOOP; ent.phase_end = 1'b1;
      end
      5'd14: begin ent.op = OP_WR; ent.addr = 8'h15; ent.data = 8'h42; ent.sync_only = 1'b1; end
      5'd15: begin ent.op = OP_WR; ent.addr = 8'h10; ent.data = 8'h00; ent.sync_only = 1'b1; end
      5'd16: begin ent.op = OP_WR; ent.addr = 8'h10; ent.data = ctl_arm; ent.sync_only = 1'b1; end
      5'd17: begin ent.op = OP_WAIT; ent.tsel = TW_SYNC; ent.sync_only = 1'b1; end
      5'd18: begin
        ent.op = OP_RD; ent.addr = 8'h21; ent.data = sync_ok;
        ent.code = FAIL_SYNC; ent.back = BACK_SYNC; ent.sync_only = 1'b1;
      end
      5'd19: begin
        ent.op = OP_RD; ent.addr = 8'h0D; ent.data = 8'h20; ent.mask = 8'h30;
        ent.code = FAIL_SYNC; ent.back = BACK_SYNC; ent.sync_only = 1'b1; ent.phase_end = 1'b1;
      end
      5'd20: begin ent.op = OP_WR; ent.addr = 8'h13; ent.data = 8'h72; end
      5'd21: begin ent.op = OP_WR; ent.addr = 8'h10; ent.data = ctl_arm; end
      5'd22: begin ent.op = OP_WR; ent.addr = 8'h10; ent.data = ctl_go; end
      5'd23: begin ent.op = OP_WAIT; ent.tsel = TW_RX; end
      5'd24: begin
        ent.op = OP_RD; ent.addr = 8'h21; ent.data = rx_ok;
        ent.code = FAIL_RX; ent.back = BACK_RX; ent.phase_end = 1'b1;
      end
      5'd25: begin ent.op = OP_WR; ent.addr = 8'h06; ent.data = 8'h00; end
      5'd26: begin ent.op = OP_WR; ent.addr = 8'h07; ent.data = 8'h02; end
      5'd27: begin ent.op = OP_WR; ent.addr = 8'h08; ent.data = 8'h00; end
      default: ;
    endcase
  end

endmodule

// File: rtl/dbs_wait_timer.sv
module dbs_wait_timer #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         last
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= len;
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign last = (cnt == W'(1));

endmodule

// File: rtl/dbs_try_ctr.sv
module dbs_try_ctr #(
  parameter int MAX_TRIES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_last
);

  localparam int CW = $clog2(MAX_TRIES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + CW'(1);
  end

  assign at_last = (cnt == CW'(MAX_TRIES - 1));

endmodule

// File: rtl/dac_bringup_seq.sv
module dac_bringup_seq
  import dbs_pkg::*;
#(
  parameter int DL_WAIT        = 160000,
  parameter int SYNC_WAIT      = 160000,
  parameter int RX_WAIT_SYNC   = 555000,
  parameter int RX_WAIT_NOSYNC = 135000,
  parameter int MAX_TRIES      = 3,
  parameter int WAIT_W         = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       master_sel,
  input  logic       sync_en,
  output logic       req,
  output logic       rd_nwr,
  output logic [7:0] addr,
  output logic [7:0] wdata,
  input  logic       ack,
  input  logic [7:0] rdata,
  output logic       busy,
  output logic       done,
  output logic [1:0] err
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER, S_DELAY} st_e;

  st_e               state;
  logic [STEP_W-1:0] step_q;
  logic              ms_q;
  logic              sync_q;
  step_t             ent;
  logic              skip;
  logic [WAIT_W-1:0] wait_len;
  logic              tmr_load, tmr_last;
  logic              rd_done, chk_ok;
  logic              try_clr, try_inc, try_last;

  dbs_step_rom u_rom (
    .idx    (step_q),
    .master (ms_q),
    .ent    (ent)
  );

  always_comb begin
    case (ent.tsel)
      TW_LOOP: wait_len = WAIT_W'(DL_WAIT);
      TW_SYNC: wait_len = WAIT_W'(SYNC_WAIT);
      default: wait_len = sync_q ? WAIT_W'(RX_WAIT_SYNC) : WAIT_W'(RX_WAIT_NOSYNC);
    endcase
  end

  assign skip     = ent.sync_only && !sync_q;
  assign tmr_load = (state == S_FETCH) && (ent.op == OP_WAIT) && !skip;
  assign rd_done  = (state == S_XFER) && ack && (ent.op == OP_RD);
  assign chk_ok   = ((rdata & ent.mask) == ent.data);
  assign try_clr  = ((state == S_IDLE) && start) || (rd_done && chk_ok && ent.phase_end);
  assign try_inc  = rd_done && !chk_ok;

  dbs_wait_timer #(.W(WAIT_W)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .len  (wait_len),
    .last (tmr_last)
  );

  dbs_try_ctr #(.MAX_TRIES(MAX_TRIES)) u_try (
    .clk     (clk),
    .rst     (rst),
    .clr     (try_clr),
    .inc     (try_inc),
    .at_last (try_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      step_q <= '0;
      ms_q   <= 1'b0;
      sync_q <= 1'b0;
      req    <= 1'b0;
      rd_nwr <= 1'b0;
      addr   <= 8'h00;
      wdata  <= 8'h00;
      busy   <= 1'b0;
      done   <= 1'b0;
      err    <= FAIL_NONE;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            ms_q   <= master_sel;
            sync_q <= sync_en;
            step_q <= '0;
            busy   <= 1'b1;
            done   <= 1'b0;
            err    <= FAIL_NONE;
            state  <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (skip) begin
            step_q <= step_q + STEP_W'(1);
          end else begin
            case (ent.op)
              OP_WR, OP_RD: begin
                req    <= 1'b1;
                rd_nwr <= (ent.op == OP_RD);
                addr   <= ent.addr;
                wdata  <= (ent.op == OP_WR) ? ent.data : 8'h00;
                state  <= S_XFER;
              end
              OP_WAIT: state <= S_DELAY;
              default: begin
                busy  <= 1'b0;
                done  <= 1'b1;
                state <= S_IDLE;
              end
            endcase
          end
        end
        S_XFER: begin
          if (ack) begin
            req    <= 1'b0;
            rd_nwr <= 1'b0;
            if (ent.op == OP_RD && !chk_ok) begin
              if (try_last) begin
                err   <= ent.code;
                done  <= 1'b1;
                busy  <= 1'b0;
                state <= S_IDLE;
              end else begin
                step_q <= ent.back;
                state  <= S_FETCH;
              end
            end else begin
              step_q <= step_q + STEP_W'(1);
              state  <= S_FETCH;
            end
          end
        end
        S_DELAY: begin
          if (tmr_last) begin
            step_q <= step_q + STEP_W'(1);
            state  <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dbs_chk.sv
module dbs_chk (
  input logic       clk,
  input logic       rst,
  input logic       req,
  input logic       ack,
  input logic       rd_nwr,
  input logic [7:0] addr,
  input logic [7:0] wdata,
  input logic       busy,
  input logic       done,
  input logic [1:0] err,
  input logic       ms_q,
  input logic       sync_q
);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> (req && $stable(addr) && $stable(wdata) && $stable(rd_nwr)));

  // R12
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (req && ack) |=> !req);

  // R12
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    req |-> busy);

  // R7
  err_done_chk: assert property (@(posedge clk) disable iff (rst)
    (err != 2'd0) |-> done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9
  sync_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !rd_nwr && addr == 8'h15) |-> sync_q);

  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(ms_q) && $stable(sync_q)));

endmodule

bind dac_bringup_seq dbs_chk u_dbs_chk (
  .clk    (clk),
  .rst    (rst),
  .req    (req),
  .ack    (ack),
  .rd_nwr (rd_nwr),
  .addr   (addr),
  .wdata  (wdata),
  .busy   (busy),
  .done   (done),
  .err    (err),
  .ms_q   (ms_q),
  .sync_q (sync_q)
);

// File: tb/dac_bringup_seq_tb_top.sv
`timescale 1ns/1ps
module dac_bringup_seq_tb_top;

  localparam int T_DL   = 40;
  localparam int T_SYNC = 50;
  localparam int T_RXS  = 90;
  localparam int T_RXN  = 30;

  typedef struct {
    bit         rd;
    logic [7:0] a;
    logic [7:0] d;
    int         gap;
  } txn_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       ms_in = 1'b0;
  logic       sen_in = 1'b0;
  logic       req, rd_nwr, busy, done;
  logic [7:0] addr, wdata;
  logic       ack = 1'b0;
  logic [7:0] rdata = 8'h00;
  logic [1:0] err;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dac_bringup_seq #(
    .DL_WAIT(T_DL), .SYNC_WAIT(T_SYNC), .RX_WAIT_SYNC(T_RXS), .RX_WAIT_NOSYNC(T_RXN)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .master_sel(ms_in), .sync_en(sen_in),
    .req(req), .rd_nwr(rd_nwr), .addr(addr), .wdata(wdata), .ack(ack), .rdata(rdata),
    .busy(busy), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h29, 8'h26, 8'h2A: return "R3";
      8'h15, 8'h0D:        return "R4";
      8'h13, 8'h21, 8'h10: return "R4/R5";
      8'h06, 8'h07, 8'h08: return "R10";
      default:             return "R2";
    endcase
  endfunction

  // ---------------- register-file model ----------------
  logic [7:0] regs [256];
  logic [7:0] last10 = 8'h00;
  bit run_ms;
  int bad_dl, bad_21, bad_0d, bad_rx;
  txn_t exp_q[$];
  int cyc = 0, rise_cyc = 0, ack_cyc = 0, lat = 0;
  logic req_prev = 1'b0;
  logic [7:0] rise_addr;

  function automatic logic [7:0] model_read(input logic [7:0] a);
    logic [7:0] v;
    v = regs[a];
    if (a == 8'h2A) begin
      if (bad_dl > 0) begin bad_dl--; v = 8'h00; end else v = 8'h01;
    end else if (a == 8'h21 && last10[1:0] == 2'b11) begin
      if (bad_rx > 0) begin bad_rx--; v = 8'h19; end else v = run_ms ? 8'h99 : 8'h09;
    end else if (a == 8'h21) begin
      if (bad_21 > 0) begin bad_21--; v = 8'h11; end else v = run_ms ? 8'h90 : 8'h00;
    end else if (a == 8'h0D) begin
      // only bits [5:4] matter; the rest are randomized
      if (bad_0d > 0) begin bad_0d--; v = 8'h10 | (8'($urandom) & 8'hC0); end
      else v = 8'h20 | (8'($urandom) & 8'hCF);
    end
    return v;
  endfunction

  task automatic serve();
    txn_t e;
    string tg;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R7", "unexpected transaction at addr", int'(addr), 0);
      rdata = 8'h00;
      return;
    end
    e = exp_q.pop_front();
    tg = tag_of(e.a);
    chk(rd_nwr == e.rd, tg, "rd_nwr", int'(rd_nwr), int'(e.rd));
    chk(addr == e.a, tg, "addr", int'(addr), int'(e.a));
    chk(addr == rise_addr, "R12", "addr held while pending", int'(addr), int'(rise_addr));
    if (!e.rd) chk(wdata == e.d, tg, "wdata", int'(wdata), int'(e.d));
    if (e.gap > 0)
      chk(rise_cyc - ack_cyc == e.gap, "R6", "wait gap", rise_cyc - ack_cyc, e.gap);
    if (rd_nwr) rdata = model_read(addr);
    else begin
      regs[addr] = wdata;
      if (addr == 8'h10) last10 = wdata;
    end
  endtask

  // Serial master stand-in: ack after 0..3 cycles, driven on the falling edge.
  always @(negedge clk) begin
    cyc++;
    if (req && !req_prev) begin rise_cyc = cyc; rise_addr = addr; end
    req_prev = req;
    if (ack) ack = 1'b0;
    else if (req) begin
      if (lat != 0) lat--;
      else begin
        serve();
        ack = 1'b1;
        ack_cyc = cyc;
        lat = $urandom_range(0, 3);
      end
    end
  end

  // ---------------- expected-sequence builder ----------------
  task automatic pw(input logic [7:0] a, input logic [7:0] d);
    txn_t t; t.rd = 0; t.a = a; t.d = d; t.gap = 0; exp_q.push_back(t);
  endtask
  // gap counts falling edges from the ack drive: N + 2 cycles after the accepting edge = N + 3
  task automatic pr(input logic [7:0] a, input int n);
    txn_t t; t.rd = 1; t.a = a; t.d = 8'h00; t.gap = (n > 0) ? n + 3 : 0; exp_q.push_back(t);
  endtask

  task automatic build_exp(input bit ms, input bit sen, input int fdl, input int f21,
                           input int f0d, input int frx, output int xerr);
    int c21, c0d, crx;
    bit pass;
    exp_q.delete();
    pw(8'h00, 8'h00); pw(8'h00, 8'h20); pw(8'h00, 8'h00);
    pw(8'h22, 8'h0F); pw(8'h23, 8'h0F);
    pw(8'h24, 8'h30); pw(8'h25, 8'h80); pw(8'h27, 8'h46); pw(8'h28, 8'h6C);
    pass = 0;
    for (int k = 0; k < 3; k++) begin
      pw(8'h29, 8'hCB); pw(8'h26, 8'h02); pw(8'h26, 8'h03); pr(8'h2A, T_DL);
      if (k >= fdl) begin pass = 1; break; end
    end
    if (!pass) begin xerr = 1; return; end
    if (sen) begin
      c21 = f21; c0d = f0d; pass = 0;
      for (int k = 0; k < 3; k++) begin
        pw(8'h15, 8'h42); pw(8'h10, 8'h00); pw(8'h10, ms ? 8'h70 : 8'h50);
        pr(8'h21, T_SYNC);
        if (c21 > 0) begin c21--; continue; end
        pr(8'h0D, 0);
        if (c0d > 0) begin c0d--; continue; end
        pass = 1; break;
      end
      if (!pass) begin xerr = 2; return; end
    end
    crx = frx; pass = 0;
    for (int k = 0; k < 3; k++) begin
      pw(8'h13, 8'h72); pw(8'h10, ms ? 8'h70 : 8'h50); pw(8'h10, ms ? 8'h73 : 8'h53);
      pr(8'h21, sen ? T_RXS : T_RXN);
      if (crx > 0) begin crx--; continue; end
      pass = 1; break;
    end
    if (!pass) begin xerr = 3; return; end
    pw(8'h06, 8'h00); pw(8'h07, 8'h02); pw(8'h08, 8'h00);
    xerr = 0;
  endtask

  task automatic run_case(input string name, input bit ms, input bit sen, input int fdl,
                          input int f21, input int f0d, input int frx, input bit poke);
    int xerr, tmo;
    string tg;
    bad_dl = fdl; bad_21 = f21; bad_0d = f0d; bad_rx = frx;
    run_ms = ms; last10 = 8'h00;
    build_exp(ms, sen, fdl, f21, f0d, frx, xerr);
    ms_in = ms; sen_in = sen;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R11: flip the mode inputs once the run has started
    ms_in = ~ms; sen_in = ~sen;
    chk(busy == 1'b1 && done == 1'b0, "R11", {name, " busy after start"}, int'({busy, done}), 2);
    if (poke) begin
      repeat (25) @(negedge clk);
      if (busy) begin start = 1'b1; @(negedge clk); start = 1'b0; end
    end
    tmo = 0;
    while (!done && tmo < 20000) begin @(negedge clk); tmo++; end
    repeat (6) @(negedge clk);
    tg = (xerr == 0) ? "R10" : "R7";
    chk(done == 1'b1, tg, {name, " done"}, int'(done), 1);
    chk(busy == 1'b0, tg, {name, " busy at end"}, int'(busy), 0);
    chk(int'(err) == xerr, tg, {name, " err code"}, int'(err), xerr);
    chk(exp_q.size() == 0, tg, {name, " missing transactions"}, exp_q.size(), 0);
  endtask

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 256; i++) regs[i] = 8'h00;
    repeat (5) @(negedge clk);
    // R1: reset state while reset is held
    chk({busy, done, err, req} == 5'b0, "R1", "outputs in reset", int'({busy, done, err, req}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, err, req} == 5'b0, "R1", "outputs after reset", int'({busy, done, err, req}), 0);

    run_case("master clean", 1, 1, 0, 0, 0, 0, 0);
    run_case("slave clean", 0, 1, 0, 0, 0, 0, 0);
    run_case("R11 start while busy", 1, 1, 0, 0, 0, 0, 1);
    run_case("R3 loop retry", 0, 1, 2, 0, 0, 0, 0);
    run_case("R7 loop exhausted", 1, 1, 3, 0, 0, 0, 0);
    run_case("R4 status retry", 1, 1, 0, 2, 0, 0, 0);
    run_case("R4 field retry", 0, 1, 0, 0, 2, 0, 0);
    run_case("R7 sync exhausted", 1, 1, 0, 1, 2, 0, 0);
    run_case("R5 rx retry", 0, 1, 0, 0, 0, 2, 0);
    run_case("R7 rx exhausted", 1, 1, 0, 0, 0, 3, 0);
    run_case("R8 counter clear", 1, 1, 2, 1, 1, 2, 0);
    run_case("R9 sync off", 1, 0, 0, 0, 0, 0, 0);
    run_case("R9 sync off slave retry", 0, 0, 1, 3, 3, 1, 0);
    for (int r = 0; r < 24; r++) begin
      run_case("random", 1'($urandom), 1'($urandom), $urandom_range(0, 3), $urandom_range(0, 2),
               $urandom_range(0, 2), $urandom_range(0, 3), 1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule